// File: doc/BRIEF.md
# Bus Start/Stop Condition Generator

This block forms a start condition or a stop condition on a two-wire serial bus (I2C) on command. It works from whatever levels the clock line and the data line have at the moment of the request. It drives the data line through an open-drain pull-down enable. It never drives the clock line. When the clock has to move, it raises a level-held request for a single falling or a single rising edge to a separate clock generator. It then waits for the edge pulses that generator's bus observer reports. After a requested clock fall, the data line is changed only once the delayed falling pulse has arrived. This keeps a data change from landing while the clock is still high.

Each step runs only if the bus is not already at that step's target level. After each data-line step or completed clock edge, a programmable settling wait follows. The block takes its confirmation from an external condition detector. The detector's start or stop pulse that matches the request ends the sequence with a done pulse. A condition that appears on the bus before the block has made its own is reported as an early condition, and the sequence is abandoned. A bus master uses this report for arbitration. Nothing else may hold either line low while the block is working.

Top module: `bus_cond_gen`

## Requirements
- R1: A synchronous active-high reset, applied at any time, returns the block to idle on the next edge: `sda_pull_o` is 0 (data line released), and `ask_fall_o`, `ask_rise_o`, `done_o` and `early_o` are 0.
- R2: Steps that are already satisfied are skipped. If the data line already has the pre-condition level (high for a start, low for a stop) and the clock is high, the condition is formed with no clock request at all. If the data line is right but the clock is low, exactly one rising request is raised and no falling request. A falling request is raised only when the data line must change while the clock is high.
- R3: When the data line must change, the order is: falling request, data line to its pre-condition level (released for a start, pulled low for a stop) while the clock is low, rising request, then the data line toggled to form the condition (pulled low for a start, released for a stop). Only the requested condition appears on the bus.
- R4: After each data-line change made to reach the pre-condition level, and after each completed rising edge, the next request or data-line change comes no sooner than DELAY+1 clock cycles later.
- R5: The block produces exactly one one-cycle `done_o` pulse, in the cycle after the detector pulse matching the request (`seen_start_i` for a start, `seen_stop_i` for a stop). `sda_pull_o` then stays 1 after a start and 0 after a stop.
- R6: After a requested clock fall, the data line does not change before the cycle that follows `scl_fall_dly_i`.
- R7: A detector pulse on `seen_start_i` or `seen_stop_i` is treated as a foreign condition if it arrives while a sequence runs and before the block's own condition is confirmed. It produces a one-cycle `early_o` pulse in the next cycle and abandons the sequence with no `done_o`. The clock requests drop and the data-line drive is left as it was.
- R8: `want_start_i` and `want_stop_i` are ignored while a sequence is in progress. They have no effect on the current sequence and are not remembered for later.
- R9: If `want_start_i` and `want_stop_i` are both high in the same idle cycle, a start condition is produced.
- R10: `ask_fall_o` and `ask_rise_o` are held high from the cycle the step begins until the cycle the matching `scl_fall_i` or `scl_rise_i` pulse is seen. They are never high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Observed clock line level |
| sda_i | input | 1 | Observed data line level |
| scl_rise_i | input | 1 | One-cycle pulse: clock line rose |
| scl_fall_i | input | 1 | One-cycle pulse: clock line fell |
| scl_fall_dly_i | input | 1 | One-cycle pulse: delayed copy of the clock fall |
| seen_start_i | input | 1 | One-cycle pulse from the condition detector: start seen |
| seen_stop_i | input | 1 | One-cycle pulse from the condition detector: stop seen |
| want_start_i | input | 1 | Request a start condition (one cycle) |
| want_stop_i | input | 1 | Request a stop condition (one cycle) |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| ask_fall_o | output | 1 | Request one clock falling edge (held until seen) |
| ask_rise_o | output | 1 | Request one clock rising edge (held until seen) |
| early_o | output | 1 | One-cycle pulse: foreign condition before our own |
| done_o | output | 1 | One-cycle pulse: requested condition confirmed |

## Verification
The bench goes after the repeated start, where the data line is held low by the block itself and the clock is high. A design that released the data line before pulling the clock down would form a stop, and one that changed the data line on the undelayed fall pulse would move the line too early. It measures the settling gaps, which a counter that is off by one would shorten. It also runs the three shortcut cases (idle bus, clock low, stop right after start), where a design that did not skip steps would issue clock requests it does not need. It injects a foreign stop while the block waits on a clock that never rises, and it issues requests during a busy sequence and together in one cycle. A design that latched a request made while busy would form an extra stop after its done pulse.

// File: rtl/bus_cond_pkg.sv
package bus_cond_pkg;

    typedef enum logic {
        COND_START = 1'b0,
        COND_STOP  = 1'b1
    } cond_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FALL_REQ,
        ST_FALL_SETTLE,
        ST_SET_PRE,
        ST_WAIT_RISE,
        ST_RISE_REQ,
        ST_WAIT_FIRE,
        ST_FIRE,
        ST_CONFIRM
    } seq_state_e;

    typedef struct packed {
        logic pull_set;
        logic pull_clr;
    } drive_cmd_t;

    // Pull-down state the data line must have just before the condition.
    function automatic logic pre_pull(cond_kind_e kind);
        return kind == COND_STOP;
    endfunction

    function automatic logic pre_level_ok(cond_kind_e kind, logic sda);
        return (kind == COND_START) ? sda : !sda;
    endfunction

    // First step of a sequence, given the bus levels at request time.
    function automatic seq_state_e entry_state(cond_kind_e kind, logic sda, logic scl);
        if (pre_level_ok(kind, sda))
            return scl ? ST_FIRE : ST_RISE_REQ;
        else
            return scl ? ST_FALL_REQ : ST_SET_PRE;
    endfunction

    function automatic logic cond_matches(cond_kind_e kind, logic seen_start, logic seen_stop);
        return (kind == COND_START) ? seen_start : seen_stop;
    endfunction

    function automatic drive_cmd_t drive_to(logic pull);
        drive_cmd_t c;
        c.pull_set = pull;
        c.pull_clr = !pull;
        return c;
    endfunction

endpackage

// File: rtl/bus_cond_delay.sv
module bus_cond_delay
    import bus_cond_pkg::*;
#(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int unsigned CW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DELAY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0) && !load;

    // R4: the settling count steps down by one each cycle once loaded
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bus_cond_drive.sv
module bus_cond_drive
    import bus_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  drive_cmd_t cmd,
    output logic       pull_o
);
    logic pull_q;

    always_ff @(posedge clk) begin
        if (rst)
            pull_q <= 1'b0;
        else if (cmd.pull_set)
            pull_q <= 1'b1;
        else if (cmd.pull_clr)
            pull_q <= 1'b0;
    end

    assign pull_o = pull_q;

    // R1: reset releases the data line
    a_r1_reset_release: assert property (@(posedge clk)
        rst |=> !pull_q);

endmodule

// File: rtl/bus_cond_seq.sv
module bus_cond_seq
    import bus_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       scl_fall_dly_i,
    input  logic       seen_start_i,
    input  logic       seen_stop_i,
    input  logic       want_start_i,
    input  logic       want_stop_i,
    input  logic       expired_i,
    output logic       load_o,
    output drive_cmd_t cmd_o,
    output logic       ask_fall_o,
    output logic       ask_rise_o,
    output logic       early_o,
    output logic       done_o
);
    seq_state_e state_q, state_d;
    cond_kind_e kind_q, kind_d;
    logic       done_q, early_q;
    logic       finish, abort, foreign;
    cond_kind_e req_kind;

    assign foreign  = seen_start_i || seen_stop_i;
    assign req_kind = want_start_i ? COND_START : COND_STOP;

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        cmd_o   = '0;
        load_o  = 1'b0;
        finish  = 1'b0;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (want_start_i || want_stop_i) begin
                    kind_d  = req_kind;
                    state_d = entry_state(req_kind, sda_i, scl_i);
                end
            end
            ST_FALL_REQ: begin
                if (foreign)         abort = 1'b1;
                else if (scl_fall_i) state_d = ST_FALL_SETTLE;
            end
            ST_FALL_SETTLE: begin
                if (foreign)             abort = 1'b1;
                else if (scl_fall_dly_i) state_d = ST_SET_PRE;
            end
            ST_SET_PRE: begin
                if (foreign) abort = 1'b1;
                else begin
                    cmd_o   = drive_to(pre_pull(kind_q));
                    load_o  = 1'b1;
                    state_d = ST_WAIT_RISE;
                end
            end
            ST_WAIT_RISE: begin
                if (foreign)        abort = 1'b1;
                else if (expired_i) state_d = ST_RISE_REQ;
            end
            ST_RISE_REQ: begin
                if (foreign) abort = 1'b1;
                else if (scl_rise_i) begin
                    load_o  = 1'b1;
                    state_d = ST_WAIT_FIRE;
                end
            end
            ST_WAIT_FIRE: begin
                if (foreign)        abort = 1'b1;
                else if (expired_i) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (foreign) abort = 1'b1;
                else begin
                    cmd_o   = drive_to(!pre_pull(kind_q));
                    state_d = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (cond_matches(kind_q, seen_start_i, seen_stop_i)) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else if (foreign) begin
                    abort = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= COND_START;
            done_q  <= 1'b0;
            early_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            done_q  <= finish;
            early_q <= abort;
        end
    end

    assign ask_fall_o = (state_q == ST_FALL_REQ);
    assign ask_rise_o = (state_q == ST_RISE_REQ);
    assign done_o     = done_q;
    assign early_o    = early_q;

    // R6: no progress out of the settle step before the delayed fall pulse
    a_r6_hold_for_dly: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FALL_SETTLE && !scl_fall_dly_i)
            |=> (state_q == ST_FALL_SETTLE || state_q == ST_IDLE));

    // R8: the condition kind cannot change while a sequence runs
    a_r8_kind_held: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(kind_q));

    // R5: done follows a detector pulse and lasts one cycle
    a_r5_done_after_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(seen_start_i || seen_stop_i));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: early report only after a detector pulse, never with done
    a_r7_early_after_pulse: assert property (@(posedge clk) disable iff (rst)
        early_o |-> ($past(seen_start_i || seen_stop_i) && !done_o));

    // R10: a clock request stays up until its edge pulse is seen
    a_r10_fall_held: assert property (@(posedge clk) disable iff (rst)
        (ask_fall_o && !scl_fall_i && !foreign) |=> ask_fall_o);

    a_r10_rise_held: assert property (@(posedge clk) disable iff (rst)
        (ask_rise_o && !scl_rise_i && !foreign) |=> ask_rise_o);

endmodule

// File: rtl/bus_cond_gen.sv
module bus_cond_gen
    import bus_cond_pkg::*;
#(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic scl_rise_i,
    input  logic scl_fall_i,
    input  logic scl_fall_dly_i,
    input  logic seen_start_i,
    input  logic seen_stop_i,
    input  logic want_start_i,
    input  logic want_stop_i,
    output logic sda_pull_o,
    output logic ask_fall_o,
    output logic ask_rise_o,
    output logic early_o,
    output logic done_o
);
    logic       load;
    logic       expired;
    drive_cmd_t cmd;

    bus_cond_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (scl_i),
        .sda_i          (sda_i),
        .scl_rise_i     (scl_rise_i),
        .scl_fall_i     (scl_fall_i),
        .scl_fall_dly_i (scl_fall_dly_i),
        .seen_start_i   (seen_start_i),
        .seen_stop_i    (seen_stop_i),
        .want_start_i   (want_start_i),
        .want_stop_i    (want_stop_i),
        .expired_i      (expired),
        .load_o         (load),
        .cmd_o          (cmd),
        .ask_fall_o     (ask_fall_o),
        .ask_rise_o     (ask_rise_o),
        .early_o        (early_o),
        .done_o         (done_o)
    );

    bus_cond_delay #(.DELAY(DELAY)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .expired (expired)
    );

    bus_cond_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .pull_o (sda_pull_o)
    );

    // R10: no clock request while both are up at once
    a_r10_one_request: assert property (@(posedge clk) disable iff (rst)
        !(ask_fall_o && ask_rise_o));

endmodule

// File: tb/tb_bus_cond_gen.sv
module tb_bus_cond_gen;
    localparam int DLY      = 4;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic want_start = 1'b0, want_stop = 1'b0;
    logic inj_start = 1'b0, inj_stop = 1'b0;
    logic bus_init = 1'b0, scl_init = 1'b1, scl_stuck = 1'b0;
    logic scl_lvl = 1'b1, scl_fall = 1'b0, scl_rise = 1'b0, scl_dly = 1'b0;
    logic det_start = 1'b0, det_stop = 1'b0, sda_prev = 1'b1;
    int   dly_cnt = 0;
    logic sda_pull, ask_fall, ask_rise, early, done;
    logic sda_bus;

    int n_checks = 0, n_fail = 0, cyc = 0;

    // stamps gathered by watch()
    int t_fall, t_dly, t_rise, t_rpulse, t_chg1, t_chg2;
    int n_fall, n_rise, n_chg, n_done, n_early, n_bstart, n_bstop;

    assign sda_bus = !sda_pull;

    always #5 clk = ~clk;

    bus_cond_gen #(.DELAY(DLY)) dut (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (scl_lvl),
        .sda_i          (sda_bus),
        .scl_rise_i     (scl_rise),
        .scl_fall_i     (scl_fall),
        .scl_fall_dly_i (scl_dly),
        .seen_start_i   (det_start || inj_start),
        .seen_stop_i    (det_stop || inj_stop),
        .want_start_i   (want_start),
        .want_stop_i    (want_stop),
        .sda_pull_o     (sda_pull),
        .ask_fall_o     (ask_fall),
        .ask_rise_o     (ask_rise),
        .early_o        (early),
        .done_o         (done)
    );

    // Clock-generator and condition-detector model of the rest of the bus
    always @(negedge clk) begin
        scl_fall  <= 1'b0;
        scl_rise  <= 1'b0;
        scl_dly   <= 1'b0;
        det_start <= 1'b0;
        det_stop  <= 1'b0;
        if (bus_init) begin
            scl_lvl <= scl_init;
            dly_cnt <= 0;
        end else begin
            if (dly_cnt != 0) begin
                dly_cnt <= dly_cnt - 1;
                if (dly_cnt == 1) scl_dly <= 1'b1;
            end
            if (ask_fall && scl_lvl) begin
                scl_lvl  <= 1'b0;
                scl_fall <= 1'b1;
                dly_cnt  <= 2;
            end else if (ask_rise && !scl_lvl && !scl_stuck) begin
                scl_lvl  <= 1'b1;
                scl_rise <= 1'b1;
            end
        end
        if (scl_lvl && sda_prev && !sda_bus) det_start <= 1'b1;
        if (scl_lvl && !sda_prev && sda_bus) det_stop  <= 1'b1;
        sda_prev <= sda_bus;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic scl_start);
        @(negedge clk);
        rst = 1'b1; want_start = 1'b0; want_stop = 1'b0;
        inj_start = 1'b0; inj_stop = 1'b0; scl_stuck = 1'b0;
        scl_init = scl_start; bus_init = 1'b1;
        repeat (3) @(negedge clk);
        bus_init = 1'b0; rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic watch(input logic ws, input logic wp, input int inj_at,
                         input int busy_at, input int ncyc);
        logic pf, pr, pp;
        t_fall = -1; t_dly = -1; t_rise = -1; t_rpulse = -1; t_chg1 = -1; t_chg2 = -1;
        n_fall = 0; n_rise = 0; n_chg = 0; n_done = 0; n_early = 0;
        n_bstart = 0; n_bstop = 0;
        pf = 1'b0; pr = 1'b0; pp = sda_pull;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            want_start = (c == 0) ? ws : 1'b0;
            want_stop  = (c == 0) ? wp : (c == busy_at);
            inj_stop   = (c == inj_at);
            if (ask_fall && !pf) begin n_fall++; if (t_fall < 0) t_fall = c; end
            if (ask_rise && !pr) begin n_rise++; if (t_rise < 0) t_rise = c; end
            pf = ask_fall; pr = ask_rise;
            if (scl_dly && t_dly < 0) t_dly = c;
            if (scl_rise && t_rpulse < 0) t_rpulse = c;
            if (sda_pull != pp) begin
                n_chg++;
                if (n_chg == 1) t_chg1 = c;
                t_chg2 = c;
            end
            pp = sda_pull;
            if (done)      n_done++;
            if (early)     n_early++;
            if (det_start) n_bstart++;
            if (det_stop)  n_bstop++;
        end
        @(negedge clk);
        want_start = 1'b0; want_stop = 1'b0; inj_stop = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b1);
        check(sda_pull == 1'b0, "R1 reset pull", int'(sda_pull), 0);
        check(!ask_fall && !ask_rise, "R1 reset requests", int'({ask_fall, ask_rise}), 0);
        check(!done && !early, "R1 reset pulses", int'({done, early}), 0);
    endtask

    task automatic t_start_idle_bus();
        do_reset(1'b1);
        watch(1'b1, 1'b0, -1, -1, 40);
        check(n_fall == 0 && n_rise == 0, "R2 idle start no clock requests", n_fall + n_rise, 0);
        check(n_done == 1, "R5 idle start done count", n_done, 1);
        check(sda_pull == 1'b1, "R5 pull held after start", int'(sda_pull), 1);
        check(n_bstart == 1 && n_bstop == 0, "R5 start formed", n_bstart * 10 + n_bstop, 10);
    endtask

    task automatic t_repeated_start();
        do_reset(1'b1);
        watch(1'b1, 1'b0, -1, -1, 30);
        watch(1'b1, 1'b0, -1, -1, 60);
        check(t_fall >= 0 && t_fall < t_chg1, "R3 fall request before data release", t_fall, t_chg1);
        check(t_chg1 > t_dly && t_dly >= 0, "R6 data change after delayed fall", t_chg1, t_dly + 1);
        check(t_rise - t_chg1 >= DLY + 1, "R4 wait after release", t_rise - t_chg1, DLY + 1);
        check(t_chg2 - t_rpulse >= DLY + 1, "R4 wait after rising edge", t_chg2 - t_rpulse, DLY + 1);
        check(n_chg == 2 && sda_pull == 1'b1, "R3 release then pull", n_chg, 2);
        check(n_bstart == 1 && n_bstop == 0, "R3 only start formed", n_bstart * 10 + n_bstop, 10);
        check(n_done == 1, "R5 repeated start done", n_done, 1);
    endtask

    task automatic t_stop_idle_bus();
        do_reset(1'b1);
        watch(1'b0, 1'b1, -1, -1, 60);
        check(n_fall == 1 && n_rise == 1, "R3 stop clock requests", n_fall * 10 + n_rise, 11);
        check(t_rise > t_chg1 && t_chg1 >= 0, "R3 pull low before rise request", t_rise, t_chg1 + 1);
        check(n_bstop == 1 && n_bstart == 0, "R3 only stop formed", n_bstop * 10 + n_bstart, 10);
        check(n_done == 1 && sda_pull == 1'b0, "R5 stop done and released", n_done, 1);
    endtask

    task automatic t_stop_after_start();
        do_reset(1'b1);
        watch(1'b1, 1'b0, -1, -1, 30);
        watch(1'b0, 1'b1, -1, -1, 30);
        check(n_fall == 0 && n_rise == 0, "R2 stop after start no clock requests", n_fall + n_rise, 0);
        check(n_bstop == 1 && n_done == 1, "R2 stop after start formed", n_bstop * 10 + n_done, 11);
    endtask

    task automatic t_start_clock_low();
        do_reset(1'b0);
        watch(1'b1, 1'b0, -1, -1, 40);
        check(n_fall == 0 && n_rise == 1, "R2 clock low single rise", n_fall * 10 + n_rise, 1);
        check(n_bstart == 1 && n_done == 1, "R2 clock low start formed", n_bstart * 10 + n_done, 11);
    endtask

    task automatic t_early();
        do_reset(1'b1);
        watch(1'b1, 1'b0, -1, -1, 30);
        scl_stuck = 1'b1;
        watch(1'b1, 1'b0, 15, -1, 30);
        check(n_early == 1, "R7 early pulse count", n_early, 1);
        check(n_done == 0, "R7 no done after early", n_done, 0);
        check(!ask_rise && !ask_fall, "R7 requests dropped", int'({ask_fall, ask_rise}), 0);
        check(sda_pull == 1'b0, "R7 drive left released", int'(sda_pull), 0);
        scl_stuck = 1'b0;
    endtask

    task automatic t_busy_ignore();
        do_reset(1'b1);
        watch(1'b1, 1'b0, -1, -1, 30);
        watch(1'b1, 1'b0, -1, 3, 70);
        check(n_done == 1 && sda_pull == 1'b1, "R8 busy request ignored, pull", int'(sda_pull), 1);
        check(n_bstop == 0 && n_fall == 1, "R8 no extra stop", n_bstop, 0);
    endtask

    task automatic t_both_requests();
        do_reset(1'b1);
        watch(1'b1, 1'b1, -1, -1, 40);
        check(sda_pull == 1'b1 && n_bstart == 1, "R9 start wins", n_bstart, 1);
        check(n_bstop == 0 && n_done == 1, "R9 one condition", n_bstop, 0);
    endtask

    task automatic t_reset_midway();
        do_reset(1'b1);
        watch(1'b1, 1'b0, -1, -1, 30);
        @(negedge clk); want_start = 1'b1;
        @(negedge clk); want_start = 1'b0;
        check(ask_fall == 1'b1, "R10 fall request held", int'(ask_fall), 1);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(sda_pull == 1'b0, "R1 midway reset releases", int'(sda_pull), 0);
        check(!ask_fall && !ask_rise, "R1 midway reset requests", int'({ask_fall, ask_rise}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset_state();
        t_start_idle_bus();
        t_repeated_start();
        t_stop_idle_bus();
        t_stop_after_start();
        t_start_clock_low();
        t_early();
        t_busy_ignore();
        t_both_requests();
        t_reset_midway();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule